// File: doc/BRIEF.md
# Packet RAM Slave Access Wrapper

This block connects a 32-bit memory-mapped slave port to a single-port storage array whose words are 35 bits wide. The extra three bits sit above the data and belong to logic elsewhere in the controller. The slave side can only move 32 bits at a time. On every slave write the wrapper therefore sets those three upper bits to one. Any later check of the upper bits then finds a known pattern on every word that software has written.

The slave address is a byte address. The two lowest bits are ignored and the bits above them pick a word. A request that falls beyond the configured depth is handled without touching storage. A write there is dropped silently. A read there completes with zero data. The full-size configuration holds 8192 words (32 KB), and the default parameter set uses a smaller depth. Reads take one clock and are returned with a one-cycle valid strobe. An error strobe travels with the read data when the upper three bits of the stored word are not all ones, which marks a word that has never been written since power-up.

Top module: `pram_slave_wrap`

## Requirements
- R1: The word index is byte address bits [BYTE_AW-1:2]. Address bits [1:0] have no effect on which word is read or written.
- R2: A write request (`req_valid`=1, `req_write`=1) to an in-range word stores `req_wdata` in the low 32 bits and forces the three upper storage bits to 1. A later read of that word has `rd_err`=0.
- R3: A read of an in-range word returns the low 32 bits last written to it. A write in cycle T is visible to a read issued in cycle T+1.
- R4: A write whose word index is at or above DEPTH leaves every stored word unchanged. In particular, the word it would alias to modulo DEPTH is not changed.
- R5: A read request (`req_valid`=1, `req_write`=0) accepted at clock edge T yields `rd_valid`=1 for exactly the cycle after edge T. `rd_valid` is 0 in every other cycle.
- R6: A read whose word index is at or above DEPTH completes with `rd_valid`=1, `rd_data`=0 and `rd_err`=0.
- R7: A read of an in-range word whose upper three bits are not all ones raises `rd_err` for the single cycle in which `rd_valid` is 1. Storage powers up as all zeros, so a never-written word returns `rd_data`=0 with `rd_err`=1.
- R8: While `rst` is high and in the first cycle after it falls, `rd_valid` and `rd_err` are 0.
- R9: A write request produces no `rd_valid` pulse, and `rd_err` is never 1 while `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BYTE_AW | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid strobe |
| rd_data | output | 32 | Read data (low 32 storage bits) |
| rd_err | output | 1 | Stored upper bits not all ones |

## Verification
Walking-one and all-ones/all-zeros data patterns show whether each of the 32 data bits reaches storage and returns without being swapped or stuck. Reads of the same word through byte offsets 1 to 3, and reads of the first and last in-range words and the first word out of range, separate correct word decode from address wrap or truncation. A write out of range whose aliased word already holds a known value shows whether that write is really dropped. Reads of never-written words, compared with reads of the same words after a write, show that the error strobe depends on the forced upper bits and not on the data.

// File: rtl/pram_pkg.sv
package pram_pkg;

    localparam int DATA_W  = 32;
    localparam int RSVD_W  = 3;
    localparam int STORE_W = DATA_W + RSVD_W;

    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        data_t             data;
    } store_word_t;

    localparam logic [RSVD_W-1:0] RSVD_MARK = '1;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic store_word_t merge_slave_write(input data_t d);
        store_word_t w;
        w.rsvd = RSVD_MARK;
        w.data = d;
        return w;
    endfunction

    function automatic logic rsvd_intact(input store_word_t w);
        return w.rsvd == RSVD_MARK;
    endfunction

endpackage

// File: rtl/pram_addr_decode.sv
module pram_addr_decode
    import pram_pkg::*;
#(
    parameter int BYTE_AW = 16,
    parameter int DEPTH   = 2048,
    localparam int WORD_AW = $clog2(DEPTH),
    localparam int FIELD_W = BYTE_AW - 2
) (
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BYTE_AW-1:0] req_addr,
    output op_e                op,
    output logic               in_range,
    output logic [WORD_AW-1:0] word_idx
);

    logic [FIELD_W-1:0] word_field;
    logic [1:0]         unused_offset;

    assign word_field    = req_addr[BYTE_AW-1:2];
    assign unused_offset = req_addr[1:0];

    always_comb begin
        in_range = ({{(32-FIELD_W){1'b0}}, word_field} < 32'(DEPTH));
        word_idx = word_field[WORD_AW-1:0];
        if (!req_valid)
            op = OP_IDLE;
        else if (req_write)
            op = OP_WRITE;
        else
            op = OP_READ;
    end

endmodule

// File: rtl/pram_store.sv
module pram_store
    import pram_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int WORD_AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [WORD_AW-1:0] idx,
    input  store_word_t        wr_word,
    output store_word_t        rd_word
);

    store_word_t mem [DEPTH];

    // power-up content model: no word carries the reserved mark
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wr_word;
        if (rd_en)
            rd_word <= mem[idx];
    end

endmodule

// File: rtl/pram_read_path.sv
module pram_read_path
    import pram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_issue,
    input  logic        rd_oor,
    input  store_word_t rd_word,
    output logic        rd_valid,
    output data_t       rd_data,
    output logic        rd_err
);

    logic valid_q;
    logic oor_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            oor_q   <= 1'b0;
        end else begin
            valid_q <= rd_issue;
            oor_q   <= rd_issue & rd_oor;
        end
    end

    always_comb begin
        rd_valid = valid_q;
        rd_data  = (valid_q && !oor_q) ? rd_word.data : '0;
        rd_err   = valid_q && !oor_q && !rsvd_intact(rd_word);
    end

    // R9
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_valid);

endmodule

// File: rtl/pram_slave_wrap.sv
module pram_slave_wrap
    import pram_pkg::*;
#(
    parameter int BYTE_AW = 16,
    parameter int DEPTH   = 2048,
    localparam int WORD_AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BYTE_AW-1:0] req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic               rd_err
);

    op_e                op;
    logic               in_range;
    logic [WORD_AW-1:0] word_idx;
    logic               wr_en;
    logic               rd_issue;
    store_word_t        wr_word;
    store_word_t        rd_word;

    pram_addr_decode #(.BYTE_AW(BYTE_AW), .DEPTH(DEPTH)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op),
        .in_range  (in_range),
        .word_idx  (word_idx)
    );

    always_comb begin
        wr_en    = (op == OP_WRITE) && in_range;
        rd_issue = (op == OP_READ);
        wr_word  = merge_slave_write(req_wdata);
    end

    pram_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .rd_en   (rd_issue && in_range),
        .idx     (word_idx),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

    pram_read_path u_rdpath (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (rd_issue),
        .rd_oor   (!in_range),
        .rd_word  (rd_word),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_err   (rd_err)
    );

    // R5
    read_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    // R9
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);

    // R6
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write &&
         ({{(34-BYTE_AW){1'b0}}, req_addr[BYTE_AW-1:2]} >= 32'(DEPTH)))
        |=> (rd_data == '0 && !rd_err));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!rd_valid && !rd_err));

endmodule

// File: tb/tb_pram_slave_wrap.sv
module tb_pram_slave_wrap;

    localparam int BYTE_AW = 16;
    localparam int DEPTH   = 2048;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [BYTE_AW-1:0] req_addr  = '0;
    logic [31:0]        req_wdata = '0;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic               rd_err;

    always #2 clk = ~clk;

    pram_slave_wrap #(.BYTE_AW(BYTE_AW), .DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_err    (rd_err)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference: written words only
    logic [31:0] model_mem [int];
    bit          exp_valid = 0;
    logic [31:0] exp_data  = '0;
    bit          exp_err   = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        check(rd_valid == exp_valid, "R5/R9 rd_valid", 32'(rd_valid), 32'(exp_valid));
        check(rd_err == (exp_valid && exp_err), "R7/R9 rd_err", 32'(rd_err),
              32'(exp_valid && exp_err));
        if (exp_valid)
            check(rd_data == exp_data, "R1/R3/R6 rd_data", rd_data, exp_data);
    endtask

    // one bus cycle: compare previous response, drive new request, predict
    task automatic cycle(input bit v, input bit w, input int addr, input logic [31:0] d);
        int widx;
        @(negedge clk);
        compare_outputs();
        req_valid = v;
        req_write = w;
        req_addr  = BYTE_AW'(addr);
        req_wdata = d;
        widx = addr >> 2;
        exp_valid = v && !w;
        exp_data  = '0;
        exp_err   = 0;
        if (v && !w && widx < DEPTH) begin
            if (model_mem.exists(widx)) exp_data = model_mem[widx];
            else exp_err = 1;
        end
        @(posedge clk);
        #0;
        if (v && w && widx < DEPTH) model_mem[widx] = d;
    endtask

    task automatic wr(input int addr, input logic [31:0] d); cycle(1, 1, addr, d); endtask
    task automatic rd(input int addr); cycle(1, 0, addr, '0); endtask
    task automatic idle(); cycle(0, 0, 0, '0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: quiet during reset
        repeat (3) begin
            @(negedge clk);
            check(!rd_valid && !rd_err, "R8 reset outputs", {30'd0, rd_valid, rd_err}, 32'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rd_valid && !rd_err, "R8 after reset", {30'd0, rd_valid, rd_err}, 32'd0);

        // R7: never-written words flag error
        rd(0);
        rd(4 * (DEPTH - 1));
        rd(4 * 17);
        idle();

        // R2/R3: walking ones, back-to-back read after write
        for (int b = 0; b < 32; b++) begin
            wr(4 * (b + 100), 32'h1 << b);
            rd(4 * (b + 100));
        end
        wr(0, 32'hFFFF_FFFF);
        wr(4 * (DEPTH - 1), 32'h0000_0000);
        rd(0);
        rd(4 * (DEPTH - 1));

        // R1: byte offsets ignored for read and write
        wr(4 * 17 + 3, 32'hA5C3_0F96);
        for (int o = 0; o < 4; o++) rd(4 * 17 + o);
        wr(4 * 18 + 1, 32'h1234_5678);
        rd(4 * 18 + 2);

        // R4: out-of-range writes dropped, including aliases
        wr(4 * 5, 32'hCAFE_0005);
        wr(4 * (DEPTH + 5), 32'hDEAD_BEEF);
        wr(4 * DEPTH, 32'hBAD0_0000);
        rd(4 * 5);
        rd(0);

        // R6: out-of-range reads return zero with no error
        rd(4 * DEPTH);
        rd(4 * (DEPTH + 5));
        rd((1 << BYTE_AW) - 1);

        // R9: writes and idles give no read strobe
        wr(4 * 40, 32'h0BAD_F00D);
        idle();
        wr(4 * 41, 32'h5555_AAAA);
        rd(4 * 40);
        rd(4 * 41);
        rd(4 * 42);
        idle();
        idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule